// File: doc/BRIEF.md
# Strobe-Started Serial ADC Reader

This block runs one complete conversion and readout on an external serial analog-to-digital converter. That converter starts a conversion from the timing of a single strobe line, not from a chip-select frame. A host pulses `start` for one cycle, with `alt_sel` choosing the primary or the alternate channel/mode. The block then runs the whole sequence by itself.

First it shapes the strobe. For the alternate selection it adds a short high-low pulse ahead of the acquisition. It holds the strobe high for the acquisition time, drops it, and waits out the conversion time. It then clocks the result out with a mode-0 serial clock as two back-to-back 8-bit transfers. The 12-bit code comes back right-aligned with a one-cycle valid pulse.

All timing comes from parameters in nanoseconds and kilohertz, converted to system-clock cycles and rounded up. With the defaults (250 MHz clock, 100 ns select phases, 1400 ns acquisition, 3700 ns conversion, 8 MHz serial clock limit), the cycle counts are as follows:

| Interval | Cycles |
|---|---|
| Select phase | 25 |
| Acquisition | 350 |
| Conversion wait | 925 |
| Serial-clock half period | 16 |

Top module: `adc_strobe_reader`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, `conv_strobe`, `ser_clk`, `busy` and `result_valid` are all 0.
- R2: With `alt_sel`=0 at acceptance, `conv_strobe` makes exactly one high pulse of ACQ_CYC cycles (350 by default), starting in the cycle after `start` is accepted. It is low whenever the block is idle.
- R3: With `alt_sel`=1 at acceptance, `conv_strobe` goes high for SEL_CYC cycles, then low for SEL_CYC cycles (25 each by default), then high for ACQ_CYC cycles.
- R4: The first rising edge of `ser_clk` comes exactly CONV_CYC+HALF_CYC cycles (941 by default) after the final fall of `conv_strobe`. `ser_clk` is never high while `conv_strobe` is high.
- R5: `ser_clk` idles low. Each of its high and low phases lasts HALF_CYC cycles (16 by default). Each conversion has exactly 16 rising edges, forming two consecutive 8-bit transfers.
- R6: `ser_din` is sampled at each rising edge of `ser_clk`, and the first bit sampled is the MSB. `result` carries the first 12 bits sampled, right-aligned, so the first bit lands in result[11]. The last four bits sampled are discarded.
- R7: `result_valid` is high for exactly one cycle per conversion, in the cycle where `ser_clk` makes its final fall. `result` changes only in that cycle.
- R8: `busy` is 1 from the cycle after acceptance through the `result_valid` cycle. A `start` while `busy` is 1 is ignored: the strobe pattern is unchanged and no extra conversion happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run a conversion |
| alt_sel | input | 1 | Channel/mode select sampled with start (1 = alternate) |
| ser_din | input | 1 | Serial data from the converter |
| conv_strobe | output | 1 | Conversion strobe to the converter |
| ser_clk | output | 1 | Mode-0 serial clock to the converter |
| busy | output | 1 | A conversion cycle is in progress |
| result | output | 12 | Right-aligned conversion code |
| result_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
Every interval is measured from the first registered change it follows. This matters because the block moves one state per timer expiry.

The strobe rises one cycle after `start` is accepted. The first serial-clock rise is due 941 cycles after the final strobe fall. Each serial-clock phase lasts 16 cycles. `result_valid` lands on the 16th falling edge.

The monitor samples on the falling system-clock edge and counts cycles between observed port transitions. It compares each count with the figure in the requirement, and pops the expected code from the scoreboard only on the valid cycle.

// File: rtl/adc_rd_pkg.sv
// Package: shared state encoding for the serial ADC reader.
// Assumes: nothing beyond the standard language.
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PRE_HI = 3'd1,
        ST_PRE_LO = 3'd2,
        ST_ACQ    = 3'd3,
        ST_CONV   = 3'd4,
        ST_SHIFT  = 3'd5,
        ST_DONE   = 3'd6
    } rd_state_t;

    // Convert a duration in ns to clock cycles at clk_khz, rounding up.
    function automatic int ns_to_cycles(input int ns, input int clk_khz);
        longint prod;
        prod = longint'(ns) * longint'(clk_khz);
        return int'((prod + 64'd999_999) / 64'd1_000_000);
    endfunction

endpackage

// File: rtl/adc_rd_timer.sv
// Module: adc_rd_timer
// A loadable down counter that flags when it has reached zero.
// Assumes: a load of value N-1 makes zero rise N cycles after the load edge.
module adc_rd_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Count down after a load; stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/adc_rd_deser.sv
// Module: adc_rd_deser
// Shifts serial data in MSB first on each sample pulse. On capture it
// stores the top RES_BITS of the XFER_BITS word as the right-aligned result.
// Assumes: capture comes after the final sample of a transfer.
module adc_rd_deser #(
    parameter int XFER_BITS = 16,
    parameter int RES_BITS  = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample,
    input  logic                sdi,
    input  logic                capture,
    output logic [RES_BITS-1:0] result
);

    logic [XFER_BITS-1:0] shreg_q;
    logic [RES_BITS-1:0]  res_q;

    // Shift in one serial bit per sample pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (sample) begin
            shreg_q <= {shreg_q[XFER_BITS-2:0], sdi};
        end
    end

    // Keep the leading bits of the finished word; drop the trailing ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (capture) begin
            res_q <= shreg_q[XFER_BITS-1 -: RES_BITS];
        end
    end

    assign result = res_q;

endmodule

// File: rtl/adc_rd_seq.sv
// Module: adc_rd_seq
// The sequencer. It shapes the conversion strobe (with the optional select
// pulse), waits for the conversion, then drives the serial clock for
// XFER_BITS periods. It tells the timer when to load and the deserializer
// when to sample and capture.
// Assumes: every *_CYC is at least 1 and fits the timer width.
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int SEL_CYC   = 25,
    parameter int ACQ_CYC   = 350,
    parameter int CONV_CYC  = 925,
    parameter int HALF_CYC  = 16,
    parameter int XFER_BITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             alt_sel,
    input  logic             tzero,
    output logic             tload,
    output logic [CNT_W-1:0] tval,
    output logic             strobe,
    output logic             sclk,
    output logic             sample,
    output logic             capture,
    output logic             busy,
    output logic             valid
);

    localparam int BIT_W = $clog2(XFER_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(XFER_BITS - 1);
    localparam logic [CNT_W-1:0] SEL_LD  = CNT_W'(SEL_CYC - 1);
    localparam logic [CNT_W-1:0] ACQ_LD  = CNT_W'(ACQ_CYC - 1);
    localparam logic [CNT_W-1:0] CONV_LD = CNT_W'(CONV_CYC - 1);
    localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(HALF_CYC - 1);

    rd_state_t        state_q;
    logic             strobe_q;
    logic             sclk_q;
    logic [BIT_W-1:0] bit_q;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && start;

    // Choose when the timer reloads, and the length of the next interval.
    always_comb begin
        tload = 1'b0;
        tval  = '0;
        case (state_q)
            ST_IDLE:   begin tload = start; tval = alt_sel ? SEL_LD : ACQ_LD; end
            ST_PRE_HI: begin tload = tzero; tval = SEL_LD;  end
            ST_PRE_LO: begin tload = tzero; tval = ACQ_LD;  end
            ST_ACQ:    begin tload = tzero; tval = CONV_LD; end
            ST_CONV:   begin tload = tzero; tval = HALF_LD; end
            ST_SHIFT:  begin tload = tzero; tval = HALF_LD; end
            default:   begin tload = 1'b0;  tval = '0;      end
        endcase
    end

    // Step the strobe, serial clock and bit count through the conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            strobe_q <= 1'b0;
            sclk_q   <= 1'b0;
            bit_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q  <= alt_sel ? ST_PRE_HI : ST_ACQ;
                    strobe_q <= 1'b1;
                end
                ST_PRE_HI: if (tzero) begin
                    state_q  <= ST_PRE_LO;
                    strobe_q <= 1'b0;
                end
                ST_PRE_LO: if (tzero) begin
                    state_q  <= ST_ACQ;
                    strobe_q <= 1'b1;
                end
                ST_ACQ: if (tzero) begin
                    state_q  <= ST_CONV;
                    strobe_q <= 1'b0;
                end
                ST_CONV: if (tzero) begin
                    state_q <= ST_SHIFT;
                    sclk_q  <= 1'b0;
                    bit_q   <= '0;
                end
                ST_SHIFT: if (tzero) begin
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                    end else begin
                        sclk_q <= 1'b0;
                        if (bit_q == LAST_BIT) begin
                            state_q <= ST_DONE;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign strobe  = strobe_q;
    assign sclk    = sclk_q;
    assign sample  = (state_q == ST_SHIFT) && tzero && !sclk_q;
    assign capture = (state_q == ST_SHIFT) && tzero && sclk_q && (bit_q == LAST_BIT);
    assign busy    = (state_q != ST_IDLE);
    assign valid   = (state_q == ST_DONE);

endmodule

// File: rtl/adc_strobe_reader.sv
// Module: adc_strobe_reader (top)
// Runs one strobe-started conversion and two-byte mode-0 readout per start
// request. Timing comes from ns/kHz parameters, rounded up to clock cycles.
// Assumes: ser_din changes on falling ser_clk edges and is stable at rising ones.
module adc_strobe_reader #(
    parameter int CLK_KHZ      = 250_000,
    parameter int SEL_NS       = 100,
    parameter int ACQ_NS       = 1400,
    parameter int CONV_NS      = 3700,
    parameter int SCLK_MAX_KHZ = 8000,
    parameter int RES_BITS     = 12,
    parameter int XFER_BITS    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                alt_sel,
    input  logic                ser_din,
    output logic                conv_strobe,
    output logic                ser_clk,
    output logic                busy,
    output logic [RES_BITS-1:0] result,
    output logic                result_valid
);

    localparam int SEL_CYC  = adc_rd_pkg::ns_to_cycles(SEL_NS, CLK_KHZ);
    localparam int ACQ_CYC  = adc_rd_pkg::ns_to_cycles(ACQ_NS, CLK_KHZ);
    localparam int CONV_CYC = adc_rd_pkg::ns_to_cycles(CONV_NS, CLK_KHZ);
    localparam int HALF_CYC = (CLK_KHZ + 2 * SCLK_MAX_KHZ - 1) / (2 * SCLK_MAX_KHZ);
    localparam int MAX_CYC  = (CONV_CYC > ACQ_CYC) ? CONV_CYC : ACQ_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic             tload;
    logic             tzero;
    logic [CNT_W-1:0] tval;
    logic             sample;
    logic             capture;

    adc_rd_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tload),
        .load_val (tval),
        .zero     (tzero)
    );

    adc_rd_seq #(
        .CNT_W     (CNT_W),
        .SEL_CYC   (SEL_CYC),
        .ACQ_CYC   (ACQ_CYC),
        .CONV_CYC  (CONV_CYC),
        .HALF_CYC  (HALF_CYC),
        .XFER_BITS (XFER_BITS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .alt_sel (alt_sel),
        .tzero   (tzero),
        .tload   (tload),
        .tval    (tval),
        .strobe  (conv_strobe),
        .sclk    (ser_clk),
        .sample  (sample),
        .capture (capture),
        .busy    (busy),
        .valid   (result_valid)
    );

    adc_rd_deser #(.XFER_BITS(XFER_BITS), .RES_BITS(RES_BITS)) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (sample),
        .sdi     (ser_din),
        .capture (capture),
        .result  (result)
    );

endmodule

// File: rtl/adc_strobe_reader_chk.sv
// Module: adc_strobe_reader_chk
// Port-level protocol checks, bound into every adc_strobe_reader instance.
// Assumes: the default 12-bit result width.
module adc_strobe_reader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        alt_sel,
    input logic        ser_din,
    input logic        conv_strobe,
    input logic        ser_clk,
    input logic        busy,
    input logic [11:0] result,
    input logic        result_valid
);

    // Strobe stays low whenever no conversion is running.
    assert_strobe_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !conv_strobe);

    // Serial clock never runs during the strobe.
    assert_no_sclk_in_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> !ser_clk);

    // Serial clock idles low outside a conversion.
    assert_sclk_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ser_clk);

    // Result moves only in the valid cycle.
    assert_result_moves_on_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> result_valid);

    // Valid lasts a single cycle.
    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // Valid falls together with the serial clock.
    assert_valid_on_last_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> ($past(ser_clk) && !ser_clk));

    // Busy covers the valid cycle and holds until it.
    assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !result_valid) |=> busy);

    // Valid is never seen while idle.
    assert_valid_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> busy);

endmodule

bind adc_strobe_reader adc_strobe_reader_chk u_chk (.*);

// File: tb/adc_strobe_reader_test.sv
// Bench: a scoreboard. A driver task pushes expected conversions, a converter
// model drives ser_din, and a monitor measures port timing and pops on valid.
module adc_strobe_reader_test;

    localparam int SEL_CYC  = 25;
    localparam int ACQ_CYC  = 350;
    localparam int CONV_CYC = 925;
    localparam int HALF_CYC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        alt_sel = 1'b0;
    logic        ser_din;
    logic        conv_strobe;
    logic        ser_clk;
    logic        busy;
    logic [11:0] result;
    logic        result_valid;

    typedef struct packed { logic [11:0] code; logic alt; } exp_t;
    exp_t exp_q[$];

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    adc_strobe_reader uut (
        .clk(clk), .rst_n(rst_n), .start(start), .alt_sel(alt_sel),
        .ser_din(ser_din), .conv_strobe(conv_strobe), .ser_clk(ser_clk),
        .busy(busy), .result(result), .result_valid(result_valid)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Converter model: MSB ready after the last strobe fall, next bit on each falling sclk.
    logic [15:0] adc_word = 16'h0;
    int          adc_idx  = 0;
    always @(negedge conv_strobe) adc_idx = 0;
    always @(negedge ser_clk)     adc_idx = adc_idx + 1;
    assign ser_din = (adc_idx < 16) ? adc_word[15 - adc_idx] : 1'b0;

    // Monitor: measures port intervals and checks them on each valid pulse.
    logic p_strobe = 1'b0, p_sclk = 1'b0;
    int hi_run = 0, lo_run = 0, n_pulse = 0;
    int w0 = 0, w1 = 0, gap = 0;
    int since_fall = 0, fall_to_rise = -1;
    int rises = 0, phase_run = 0, n_valid = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            since_fall++;
            phase_run++;
            if (conv_strobe) hi_run++; else lo_run++;
            if (conv_strobe && !p_strobe) begin
                if (n_pulse == 1) gap = lo_run;
                hi_run = 1;
            end
            if (!conv_strobe && p_strobe) begin
                if (n_pulse == 0) w0 = hi_run; else w1 = hi_run;
                n_pulse++;
                lo_run = 1;
                since_fall = 0;
            end
            if (ser_clk != p_sclk) begin
                if (rises > 0 && phase_run != HALF_CYC)
                    check("R5", "sclk phase length", phase_run, HALF_CYC);
                phase_run = 0;
                if (ser_clk) begin
                    if (rises == 0) fall_to_rise = since_fall;
                    rises++;
                end
            end
            if (result_valid) begin
                n_valid++;
                check("R7", "valid on final sclk fall", int'(p_sclk && !ser_clk), 1);
                check("R5", "rising sclk edges", rises, 16);
                check("R4", "strobe fall to first sclk rise", fall_to_rise, CONV_CYC + HALF_CYC);
                check("R8", "busy during valid", int'(busy), 1);
                if (exp_q.size() == 0) begin
                    check("R8", "unexpected conversion", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R6", "result code", int'(result), int'(e.code));
                    if (e.alt) begin
                        check("R3", "pulse count", n_pulse, 2);
                        check("R3", "select high width", w0, SEL_CYC);
                        check("R3", "select low width", gap, SEL_CYC);
                        check("R3", "acquisition width", w1, ACQ_CYC);
                    end else begin
                        check("R2", "pulse count", n_pulse, 1);
                        check("R2", "acquisition width", w0, ACQ_CYC);
                    end
                end
                n_pulse = 0; rises = 0; fall_to_rise = -1;
            end
            p_strobe = conv_strobe;
            p_sclk   = ser_clk;
        end
    end

    // Driver: wait for idle, load the model, push the expectation, pulse start.
    task automatic run_conv(input logic [11:0] code, input logic [3:0] junk,
                            input logic alt, input logic poke_busy);
        while (busy) @(negedge clk);
        adc_word = {code, junk};
        exp_q.push_back('{code: code, alt: alt});
        start   = 1'b1;
        alt_sel = alt;
        @(negedge clk);
        start   = 1'b0;
        alt_sel = 1'b0;
        check("R8", "busy after accept", int'(busy), 1);
        if (poke_busy) begin
            repeat (10) @(negedge clk);
            start = 1'b1; alt_sel = ~alt;
            @(negedge clk);
            start = 1'b0; alt_sel = 1'b0;
            repeat (1000) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "strobe in reset", int'(conv_strobe), 0);
        check("R1", "sclk in reset", int'(ser_clk), 0);
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "valid in reset", int'(result_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "strobe after reset", int'(conv_strobe), 0);
        run_conv(12'hABC, 4'hF, 1'b0, 1'b0);
        run_conv(12'h5A3, 4'h5, 1'b1, 1'b0);
        run_conv(12'hFFF, 4'h0, 1'b0, 1'b0);
        run_conv(12'h000, 4'hF, 1'b1, 1'b0);
        run_conv(12'h801, 4'hA, 1'b0, 1'b1);
        repeat (50) @(negedge clk);
        check("R8", "ignored start launched nothing", int'(busy), 0);
        check("R2", "strobe low when idle", int'(conv_strobe), 0);
        check("R8", "valid pulse count", n_valid, 5);
        check("R6", "scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule